// File: doc/BRIEF.md
# Synchronous Clock Stop Gating Controller

This block turns a set of free-running source clocks into gated output clocks that can be stopped and restarted without short or stretched pulses. It serves three groups of outputs. The first is three differential processor-side pairs that idle with the true leg high and the complement low. The second is seven PCI-rate outputs that idle low. The third is three flexible PCI-rate outputs, each of which can be set to stop with the others or to keep running. Two 48 MHz outputs sit beside these groups and are gated only by their own enables.

Two active-low stop requests control the stops. The processor stop is synchronised on falling edges of the processor clock. The PCI stop is the AND of an external pin and a software run bit, and it is synchronised on rising edges of the PCI clock. Per-output enable bits and free-run selects come from a register block as static levels. Each output has one gate flop that updates only while its source clock sits in the output's idle phase, so every change takes effect on a clean clock boundary.

Top module: `clk_stop_gate`

## Requirements
- R1: When `cpu_stop_n` is driven low during the high phase of `cpu_clk`, each pair with `cpu_free_run` bit 0 shows exactly two more rising edges on its true leg and then holds true = 1, complement = 0.
- R2: A pair whose `cpu_free_run` bit is 1 keeps toggling while `cpu_stop_n` is low.
- R3: A pair whose `cpu_en` bit is 0 holds true = 1, complement = 0, whatever the stop request or free-run bit.
- R4: After `cpu_stop_n` returns high during the high phase of `cpu_clk`, a stopped pair makes its first edge on the third falling edge of `cpu_clk`, and its first pulse is a full half period.
- R5: The PCI stop takes effect when `pci_stop_n` is 0 or `pci_sw_run` is 0. The seven `pci_out` outputs then stop low.
- R6: A flexible output stops with the PCI stop when its `pcif_stop_sel` bit is 1. When that bit is 0 it keeps running.
- R7: When the PCI stop changes during the high phase of `pci_clk`, a stopping output shows exactly five more edges and ends low. A resuming output shows its first rising edge on the third rising edge of `pci_clk`.
- R8: A 0 in `pci_en`, `pcif_en` or `en48` forces that output low. An enabled output toggles at its source clock rate. The 48 MHz outputs ignore both stop requests.
- R9: Under any sequence of enable, free-run and stop changes, every high and low interval of every output lasts at least one half period of its source clock.
- R10: While `rst_n` is low, all pairs show true = 1, complement = 0, and all other outputs are low and do not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Free-running processor-side source clock |
| pci_clk | input | 1 | Free-running PCI-rate source clock |
| clk48 | input | 1 | Free-running 48 MHz source clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in every domain |
| cpu_stop_n | input | 1 | Asynchronous active-low processor stop request |
| pci_stop_n | input | 1 | Asynchronous active-low PCI stop pin |
| pci_sw_run | input | 1 | Software PCI run bit; 0 stops the same as the pin |
| cpu_en | input | 3 | Per-pair enable, 1 = run |
| cpu_free_run | input | 3 | Per-pair stop override, 1 = ignore processor stop |
| pci_en | input | 7 | Per-output enable for the PCI outputs |
| pcif_en | input | 3 | Per-output enable for the flexible outputs |
| pcif_stop_sel | input | 3 | 1 = flexible output obeys the PCI stop, 0 = free running |
| en48 | input | 2 | Per-output enable for the 48 MHz outputs |
| cpu_t | output | 3 | True legs of the processor pairs |
| cpu_c | output | 3 | Complement legs of the processor pairs |
| pci_out | output | 7 | Stoppable PCI outputs |
| pcif_out | output | 3 | Flexible PCI outputs |
| out48 | output | 2 | Gated 48 MHz outputs |

## Verification
The bench counts output edges inside windows that start exactly when a stop request changes. If a synchroniser had one flop too few or too many, or if a gate flop sampled on the wrong clock phase, the edge count after a stop or a resume would differ from four, five or six. An edge monitor records the shortest interval between edges on each output while enables, free-run bits and both stop requests change at random. A gate that updates while its clock is in the active phase would show up there as a runt pulse. The polarity of the two free-run selects is checked directly, because swapping them would stop the running outputs and leave the stoppable ones running.

// File: rtl/clkgate_pkg.sv
// Shared types for the clock stop gating controller.
// Assumes: imported by every module of the block.
package clkgate_pkg;
    // Clock edge on which a synchroniser samples.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_e;
endpackage

// File: rtl/stop_sync.sv
// Multi-flop synchroniser for an asynchronous active-low stop request.
// The sampling edge is chosen by a parameter. Reset clears the chain,
// so the request reads as asserted until it has passed through.
// Assumes: STAGES >= 2; rst_n is synchronous to clk.
module stop_sync
    import clkgate_pkg::*;
#(
    parameter int    STAGES = 2,
    parameter edge_e EDGE   = EDGE_RISE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_n
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        if (EDGE == EDGE_FALL) begin : g_fall
            // Shift the request in on falling edges.
            always_ff @(negedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[LAST-1:0], async_n};
            end
        end else begin : g_rise
            // Shift the request in on rising edges.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[LAST-1:0], async_n};
            end
        end
    endgenerate

    assign sync_n = chain_q[LAST];
endmodule

// File: rtl/clk_gate_low.sv
// Single-ended clock gate that idles low.
// The gate flop updates on the falling edge, while the clock is low, so an
// enable change can neither cut a high pulse short nor start a partial one.
// Assumes: run is stable around the falling edge of clk.
module clk_gate_low (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic gclk
);
    logic en_q;

    // Capture the run request during the low phase.
    always_ff @(negedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= run;
    end

    assign gclk = clk & en_q;
endmodule

// File: rtl/clk_gate_diff.sv
// Differential clock gate that idles with true high and complement low.
// The gate flop updates on the rising edge, where both legs already sit at
// their idle levels, so stopping and restarting produce only full pulses.
// Assumes: run is stable around the rising edge of clk.
module clk_gate_diff (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic gclk_t,
    output logic gclk_c
);
    logic en_q;

    // Capture the run request at the edge that matches the idle levels.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= run;
    end

    assign gclk_t = clk | ~en_q;
    assign gclk_c = ~clk & en_q;
endmodule

// File: rtl/clk_stop_gate.sv
// Synchronous clock stop gating controller.
// Synchronises the processor stop on falling edges and the combined PCI stop
// on rising edges, then builds a per-output run term and gates each source
// clock through a phase-safe gate flop.
// Assumes: source clocks free-run; enable and select inputs are quasi-static
// levels from a register block; rst_n is held across several cycles of
// every source clock.
module clk_stop_gate
    import clkgate_pkg::*;
#(
    parameter int N_CPU       = 3,
    parameter int N_PCI       = 7,
    parameter int N_PCIF      = 3,
    parameter int N_48        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              cpu_clk,
    input  logic              pci_clk,
    input  logic              clk48,
    input  logic              rst_n,
    input  logic              cpu_stop_n,
    input  logic              pci_stop_n,
    input  logic              pci_sw_run,
    input  logic [N_CPU-1:0]  cpu_en,
    input  logic [N_CPU-1:0]  cpu_free_run,
    input  logic [N_PCI-1:0]  pci_en,
    input  logic [N_PCIF-1:0] pcif_en,
    input  logic [N_PCIF-1:0] pcif_stop_sel,
    input  logic [N_48-1:0]   en48,
    output logic [N_CPU-1:0]  cpu_t,
    output logic [N_CPU-1:0]  cpu_c,
    output logic [N_PCI-1:0]  pci_out,
    output logic [N_PCIF-1:0] pcif_out,
    output logic [N_48-1:0]   out48
);
    logic              cpu_stop_s;
    logic              pci_stop_raw_n;
    logic              pci_stop_s;
    logic [N_CPU-1:0]  cpu_run;
    logic [N_PCI-1:0]  pci_run;
    logic [N_PCIF-1:0] pcif_run;

    // The PCI stop is asserted when either the pin or the software bit is low.
    assign pci_stop_raw_n = pci_stop_n & pci_sw_run;

    stop_sync #(.STAGES(SYNC_STAGES), .EDGE(EDGE_FALL)) u_cpu_sync (
        .clk     (cpu_clk),
        .rst_n   (rst_n),
        .async_n (cpu_stop_n),
        .sync_n  (cpu_stop_s)
    );

    stop_sync #(.STAGES(SYNC_STAGES), .EDGE(EDGE_RISE)) u_pci_sync (
        .clk     (pci_clk),
        .rst_n   (rst_n),
        .async_n (pci_stop_raw_n),
        .sync_n  (pci_stop_s)
    );

    // Processor pairs: the free-run bit set to 1 overrides the stop.
    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
        assign cpu_run[i] = cpu_en[i] & (cpu_free_run[i] | cpu_stop_s);

        clk_gate_diff u_gate (
            .clk    (cpu_clk),
            .rst_n  (rst_n),
            .run    (cpu_run[i]),
            .gclk_t (cpu_t[i]),
            .gclk_c (cpu_c[i])
        );

        // R1 and R3: a dropped run term leaves the pair idle on the next cycle.
        assert_cpu_idle_R3: assert property (@(posedge cpu_clk) disable iff (!rst_n)
            !cpu_run[i] |=> (cpu_t[i] && !cpu_c[i]));

        // R2: an enabled free-running pair keeps driving its low phase.
        assert_cpu_free_run_R2: assert property (@(posedge cpu_clk) disable iff (!rst_n)
            (cpu_en[i] && cpu_free_run[i]) |=> cpu_c[i]);
    end

    // PCI outputs: always stoppable.
    for (genvar i = 0; i < N_PCI; i++) begin : g_pci
        assign pci_run[i] = pci_en[i] & pci_stop_s;

        clk_gate_low u_gate (
            .clk   (pci_clk),
            .rst_n (rst_n),
            .run   (pci_run[i]),
            .gclk  (pci_out[i])
        );

        // R5: with the stop seen (or the output disabled) the next high phase is suppressed.
        assert_pci_stop_low_R5: assert property (@(negedge pci_clk) disable iff (!rst_n)
            !pci_run[i] |=> !pci_out[i]);
    end

    // Flexible outputs: a select bit of 0 means free running (opposite sense to the pairs).
    for (genvar i = 0; i < N_PCIF; i++) begin : g_pcif
        assign pcif_run[i] = pcif_en[i] & (~pcif_stop_sel[i] | pci_stop_s);

        clk_gate_low u_gate (
            .clk   (pci_clk),
            .rst_n (rst_n),
            .run   (pcif_run[i]),
            .gclk  (pcif_out[i])
        );

        // R6: an enabled free-running flexible output produces its high phase.
        assert_pcif_free_run_R6: assert property (@(negedge pci_clk) disable iff (!rst_n)
            (pcif_en[i] && !pcif_stop_sel[i]) |=> pcif_out[i]);
    end

    // 48 MHz outputs: gated by their enables only.
    for (genvar i = 0; i < N_48; i++) begin : g_48
        clk_gate_low u_gate (
            .clk   (clk48),
            .rst_n (rst_n),
            .run   (en48[i]),
            .gclk  (out48[i])
        );

        // R8: a cleared enable forces the output low from the next high phase on.
        assert_out48_forced_low_R8: assert property (@(negedge clk48) disable iff (!rst_n)
            !en48[i] |=> !out48[i]);
    end
endmodule

// File: tb/clk_stop_gate_tb_top.sv
// Directed bench for the clock stop gating controller.
// Every clock edge falls on an even nanosecond and every stimulus change on
// an odd one, so no result depends on process order at an edge.

// Edge monitor: counts changes of one output and tracks the shortest
// interval between edges that both lie inside the current window.
module edge_mon (
    input  logic sig,
    input  int   win_id,
    input  int   win_t0,
    output int   n_edges,
    output int   min_dur
);
    int cnt    = 0;
    int mind   = 1000000;
    int last_t = -1;
    int seen   = -1;

    // Record each edge and the interval since the previous one.
    always @(sig) begin
        int now;
        now = int'($time);
        if (seen != win_id) begin
            seen = win_id;
            mind = 1000000;
        end
        cnt = cnt + 1;
        if (last_t >= win_t0 && (now - last_t) < mind) mind = now - last_t;
        last_t = now;
    end

    assign n_edges = cnt;
    assign min_dur = mind;
endmodule

module clk_stop_gate_tb_top;
    localparam int NO = 18;

    logic       cpu_clk = 1'b0;
    logic       pci_clk = 1'b0;
    logic       clk48   = 1'b0;
    logic       rst_n;
    logic       cpu_stop_n, pci_stop_n, pci_sw_run;
    logic [2:0] cpu_en, cpu_free_run, pcif_en, pcif_stop_sel;
    logic [6:0] pci_en;
    logic [1:0] en48;
    logic [2:0] cpu_t, cpu_c, pcif_out;
    logic [6:0] pci_out;
    logic [1:0] out48;

    logic [NO-1:0] outs;
    int cnt_a [NO];
    int min_a [NO];
    int base  [NO];
    int d     [NO];
    int win_id = 0;
    int win_t0 = 0;
    int n_chk  = 0;
    int n_fail = 0;

    // Source clocks: 50 MHz, 25 MHz and a 48 MHz stand-in (24 ns period).
    always #10 cpu_clk = ~cpu_clk;
    initial begin #4; forever #20 pci_clk = ~pci_clk; end
    initial begin #2; forever #12 clk48 = ~clk48; end

    clk_stop_gate dut_i (
        .cpu_clk       (cpu_clk),
        .pci_clk       (pci_clk),
        .clk48         (clk48),
        .rst_n         (rst_n),
        .cpu_stop_n    (cpu_stop_n),
        .pci_stop_n    (pci_stop_n),
        .pci_sw_run    (pci_sw_run),
        .cpu_en        (cpu_en),
        .cpu_free_run  (cpu_free_run),
        .pci_en        (pci_en),
        .pcif_en       (pcif_en),
        .pcif_stop_sel (pcif_stop_sel),
        .en48          (en48),
        .cpu_t         (cpu_t),
        .cpu_c         (cpu_c),
        .pci_out       (pci_out),
        .pcif_out      (pcif_out),
        .out48         (out48)
    );

    // Index map: 0-2 true legs, 3-5 complements, 6-12 PCI, 13-15 flexible, 16-17 48 MHz.
    assign outs = {out48, pcif_out, pci_out, cpu_c, cpu_t};

    for (genvar g = 0; g < NO; g++) begin : g_mon
        edge_mon u_mon (
            .sig     (outs[g]),
            .win_id  (win_id),
            .win_t0  (win_t0),
            .n_edges (cnt_a[g]),
            .min_dur (min_a[g])
        );
    end

    function automatic int half_of(int i);
        if (i < 6)       return 10;
        else if (i < 16) return 20;
        else             return 12;
    endfunction

    task automatic chk_eq(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_ge(string req, string what, int act, int lim);
        n_chk++;
        if (act < lim) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected >= %0d", req, what, act, lim);
        end
    endtask

    task automatic open_win();
        win_id = win_id + 1;
        win_t0 = int'($time);
        for (int i = 0; i < NO; i++) base[i] = cnt_a[i];
    endtask

    task automatic close_win();
        for (int i = 0; i < NO; i++) d[i] = cnt_a[i] - base[i];
    endtask

    task automatic chk_min(string req, int i);
        if (d[i] > 1) chk_ge(req, $sformatf("min interval out %0d", i), min_a[i], half_of(i));
    endtask

    // R10: idle levels and no activity while reset is held.
    task automatic t_reset();
        #51;
        open_win();
        #150;
        close_win();
        for (int i = 0; i < NO; i++) chk_eq("R10", $sformatf("edges in reset out %0d", i), d[i], 0);
        chk_eq("R10", "cpu_t in reset", int'(cpu_t), 7);
        chk_eq("R10", "cpu_c in reset", int'(cpu_c), 0);
        chk_eq("R10", "pci_out in reset", int'(pci_out), 0);
        chk_eq("R10", "pcif/48 in reset", int'({pcif_out, out48}), 0);
        rst_n = 1'b1;
        #300;
    endtask

    // R8, R9: all outputs toggle at their source rate with full intervals.
    task automatic t_run();
        open_win();
        #400;
        close_win();
        for (int i = 0; i < NO; i++) begin
            chk_ge("R8", $sformatf("running edges out %0d", i), d[i], 400 / half_of(i) - 1);
            chk_min("R9", i);
        end
    endtask

    // R1, R2, R4: processor stop and resume with pair 1 free running.
    task automatic t_cpu_stop_resume();
        cpu_free_run = 3'b010;
        #100;
        @(posedge cpu_clk); #5;
        open_win();
        cpu_stop_n = 1'b0;
        #300;
        close_win();
        chk_eq("R1", "pair0 true edges after stop", d[0], 4);
        chk_eq("R1", "pair2 true edges after stop", d[2], 4);
        chk_eq("R1", "pair0 comp edges after stop", d[3], 4);
        chk_eq("R1", "stopped true levels", int'({cpu_t[2], cpu_t[0]}), 3);
        chk_eq("R1", "stopped comp levels", int'({cpu_c[2], cpu_c[0]}), 0);
        chk_ge("R2", "free-run pair true edges", d[1], 29);
        chk_ge("R2", "free-run pair comp edges", d[4], 29);
        for (int i = 0; i < 6; i++) chk_min("R9", i);
        open_win();
        #200;
        close_win();
        chk_eq("R1", "pair0 stays stopped", d[0], 0);
        chk_ge("R2", "pair1 still running", d[1], 19);
        @(posedge cpu_clk); #5;
        open_win();
        cpu_stop_n = 1'b1;
        #100;
        close_win();
        chk_eq("R4", "pair0 true edges after resume", d[0], 6);
        chk_eq("R4", "pair2 true edges after resume", d[2], 6);
        chk_eq("R4", "pair2 comp edges after resume", d[5], 6);
        chk_min("R4", 0);
        chk_min("R4", 5);
        cpu_free_run = 3'b000;
        #100;
    endtask

    // R3: a disabled pair idles even with its free-run bit set.
    task automatic t_cpu_disable();
        cpu_en       = 3'b011;
        cpu_free_run = 3'b100;
        #100;
        open_win();
        #200;
        close_win();
        chk_eq("R3", "disabled pair true edges", d[2], 0);
        chk_eq("R3", "disabled pair comp edges", d[5], 0);
        chk_eq("R3", "disabled pair levels", int'({cpu_t[2], cpu_c[2]}), 2);
        chk_ge("R3", "enabled pair0 runs", d[0], 19);
        cpu_en       = 3'b111;
        cpu_free_run = 3'b000;
        #100;
    endtask

    // R5, R6, R7, R8: PCI stop by pin, flexible output 1 free running.
    task automatic t_pci_pin();
        pcif_stop_sel = 3'b101;
        #100;
        @(posedge pci_clk); #5;
        open_win();
        pci_stop_n = 1'b0;
        #300;
        close_win();
        for (int i = 6; i < 13; i++) chk_eq("R7", $sformatf("edges after stop out %0d", i), d[i], 5);
        chk_eq("R5", "stopped pci level", int'(pci_out), 0);
        chk_eq("R6", "stoppable flex0 edges", d[13], 5);
        chk_eq("R6", "stoppable flex2 edges", d[15], 5);
        chk_ge("R6", "free flex1 edges", d[14], 14);
        chk_ge("R8", "48 MHz out0 ignores stop", d[16], 24);
        chk_ge("R8", "48 MHz out1 ignores stop", d[17], 24);
        @(posedge pci_clk); #5;
        open_win();
        pci_stop_n = 1'b1;
        #200;
        close_win();
        for (int i = 6; i < 13; i++) begin
            chk_eq("R7", $sformatf("edges after resume out %0d", i), d[i], 5);
            chk_min("R9", i);
        end
        #100;
    endtask

    // R5: the software run bit alone stops the PCI outputs.
    task automatic t_pci_reg();
        pci_sw_run = 1'b0;
        #200;
        open_win();
        #200;
        close_win();
        for (int i = 6; i < 13; i++) chk_eq("R5", $sformatf("sw stop edges out %0d", i), d[i], 0);
        chk_eq("R5", "sw stop pci level", int'(pci_out), 0);
        chk_ge("R6", "free flex1 under sw stop", d[14], 9);
        pci_sw_run    = 1'b1;
        pcif_stop_sel = 3'b111;
        #200;
    endtask

    // R8: cleared enables force single-ended outputs low.
    task automatic t_enables();
        pci_en  = 7'b1110111;
        pcif_en = 3'b110;
        en48    = 2'b01;
        #100;
        open_win();
        #300;
        close_win();
        chk_eq("R8", "pci3 disabled edges", d[9], 0);
        chk_eq("R8", "pci3 disabled level", int'(pci_out[3]), 0);
        chk_eq("R8", "flex0 disabled edges", d[13], 0);
        chk_eq("R8", "flex0 disabled level", int'(pcif_out[0]), 0);
        chk_eq("R8", "48 MHz out1 disabled edges", d[17], 0);
        chk_eq("R8", "48 MHz out1 disabled level", int'(out48[1]), 0);
        chk_ge("R8", "pci0 enabled runs", d[6], 14);
        chk_ge("R8", "48 MHz out0 enabled runs", d[16], 24);
        pci_en  = 7'h7F;
        pcif_en = 3'b111;
        en48    = 2'b11;
        #100;
    endtask

    // R9: random control changes never yield a short interval.
    task automatic t_no_runt();
        logic [15:0] lf;
        int          k3;
        lf = 16'hACE1;
        @(posedge cpu_clk); #1;
        open_win();
        for (int s = 0; s < 80; s++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            k3 = int'(lf[5:4]) % 3;
            case (lf[2:0])
                3'd0: cpu_stop_n        = ~cpu_stop_n;
                3'd1: pci_stop_n        = ~pci_stop_n;
                3'd2: cpu_en[k3]        = ~cpu_en[k3];
                3'd3: cpu_free_run[k3]  = ~cpu_free_run[k3];
                3'd4: pci_en[int'(lf[7:4]) % 7] = ~pci_en[int'(lf[7:4]) % 7];
                3'd5: pcif_en[k3]       = ~pcif_en[k3];
                3'd6: pcif_stop_sel[k3] = ~pcif_stop_sel[k3];
                default: begin
                    en48[lf[4]] = ~en48[lf[4]];
                    if (lf[5]) pci_sw_run = ~pci_sw_run;
                end
            endcase
            #(2 * (int'(lf[9:6]) + 1));
        end
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1; pci_sw_run = 1'b1;
        cpu_en = 3'b111; cpu_free_run = 3'b000;
        pci_en = 7'h7F; pcif_en = 3'b111; pcif_stop_sel = 3'b111; en48 = 2'b11;
        #300;
        close_win();
        for (int i = 0; i < NO; i++) chk_min("R9", i);
    endtask

    // Main sequence.
    initial begin
        rst_n = 1'b0;
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1; pci_sw_run = 1'b1;
        cpu_en = 3'b111; cpu_free_run = 3'b000;
        pci_en = 7'h7F; pcif_en = 3'b111; pcif_stop_sel = 3'b111; en48 = 2'b11;
        t_reset();
        t_run();
        t_cpu_stop_resume();
        t_cpu_disable();
        t_pci_pin();
        t_pci_reg();
        t_enables();
        t_no_runt();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #200000;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail + 1);
        $finish;
    end
endmodule